// File: doc/BRIEF.md
# Pin Edge Interrupt and Wakeup Detector

This block watches the already-synchronized input levels of a bank of general-purpose pins and turns level changes into latched events. Each pin has four enable bits: one for rising and one for falling edges toward the interrupt path, and one for rising and one for falling edges toward the wakeup path. Edges are found by comparing each pin's present level with its level one clock earlier, so only transitions count. A level held high or low never raises an event.

Interrupt events set sticky per-pin pending bits. A single interrupt output is high while any pending bit is set. Wakeup events set a second set of sticky pending bits, but only on pins whose sleep-control input bit is 0. These drive a wakeup output. A software agent reads the pending bits through a simple register port. It acknowledges them by writing ones to a clear register, which clears both the interrupt and the wake pending bits of the pins it names. The clock and reset are synchronous, and the reset is active high.

Top module: `edge_wake_detector`

## Requirements
- R1: After reset every readable register (word addresses 0 to 7) reads 0, and both `irq_o` and `wake_o` are 0.
- R2: Word 0 is the rising-interrupt enable mask. A 0-to-1 transition on a pin whose bit in word 0 is 1 sets that pin's bit in the interrupt status (word 4). A 1-to-0 transition on a pin enabled only in word 0 sets nothing.
- R3: Word 1 is the falling-interrupt enable mask. A 1-to-0 transition on a pin whose bit in word 1 is 1 sets its status bit. A 0-to-1 transition on a pin enabled only in word 1 sets nothing.
- R4: Words 0 to 3 are independent read/write masks, each read back exactly as written. A pin enabled in both word 0 and word 1 sets its status on either edge direction.
- R5: A pin held at a constant level never sets a status bit, however long it is held.
- R6: Writing word 5 clears each status bit whose data bit is 1 and leaves the other status bits unchanged. Word 5 reads 0. Writes to words 4, 6 and 7 have no effect.
- R7: When an edge sets a status bit in the same cycle that word 5 clears it, the bit ends up set.
- R8: `irq_o` equals the OR of all interrupt status bits. It updates on the same clock edge as the status register.
- R9: Word 2 is the rising-wake mask and word 3 is the falling-wake mask. A matching edge on an enabled pin sets that pin's bit in the wake pending register (word 6). `wake_o` equals the OR of word 6 and updates on the same edge.
- R10: A pin whose `sleep_ctl` bit is 1 sets no wake pending bit on any edge. The interrupt status path ignores `sleep_ctl`.
- R11: Clearing an enable bit does not clear a status bit that is already latched.
- R12: A write to word 5 also clears the named bits of the wake pending register. `wake_o` falls once no wake bit remains set.
- R13: Register reads return data one clock after the read address is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_lvl | input | N (32) | Synchronized pin levels |
| sleep_ctl | input | N (32) | Per-pin wake disable, 1 blocks wake detection |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write word address |
| wr_data | input | N (32) | Register write data |
| rd_addr | input | 3 | Register read word address |
| rd_data | output | N (32) | Registered read data, one cycle latency |
| irq_o | output | 1 | Any interrupt pending |
| wake_o | output | 1 | Any wake event pending |

## Verification
The bench probes the edge-direction split. It drives the opposite edge on a pin with a single enable bit, and a design that crossed or merged the masks would latch status there. It holds a pin high after acknowledging it, which catches a level-triggered design that re-sets the bit at once. It also collides an edge with the clear of the same bit, where a clear-wins design would drop the event. It then drives edges on a pin whose sleep-control bit is 1, which a design that ignored the gate would latch as a wake event while the interrupt path still had to record it.

// File: rtl/ewd_pkg.sv
package ewd_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    SEL_RISE_IRQ  = 3'd0,
    SEL_FALL_IRQ  = 3'd1,
    SEL_RISE_WAKE = 3'd2,
    SEL_FALL_WAKE = 3'd3,
    SEL_STATUS    = 3'd4,
    SEL_CLEAR     = 3'd5,
    SEL_WAKE_PEND = 3'd6,
    SEL_SPARE     = 3'd7
  } reg_sel_e;

  localparam int NUM_MASKS = 4;
endpackage

// File: rtl/ewd_edge_sense.sv
module ewd_edge_sense #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] prev_q;

  // prev_q tracks the pin level even during reset, so no false edge appears at release
  always_ff @(posedge clk) begin
    prev_q <= lvl;
  end

  always_comb begin
    if (rst) begin
      rise = '0;
      fall = '0;
    end else begin
      rise = lvl & ~prev_q;
      fall = ~lvl & prev_q;
    end
  end
endmodule

// File: rtl/ewd_cfg_regs.sv
module ewd_cfg_regs
  import ewd_pkg::*;
#(
  parameter int N = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [N-1:0]               wr_data,
  output logic [NUM_MASKS-1:0][N-1:0] masks
);
  for (genvar g = 0; g < NUM_MASKS; g++) begin : g_mask
    logic [N-1:0] m_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        m_q <= '0;
      end else if (wr_en && (wr_addr == ADDR_W'(g))) begin
        m_q <= wr_data;
      end
    end
    assign masks[g] = m_q;
  end
endmodule

// File: rtl/ewd_sticky.sv
module ewd_sticky #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  output logic [N-1:0] pend_q,
  output logic         any_q
);
  logic [N-1:0] pend_nxt;

  // a set arriving with a clear of the same bit wins
  always_comb begin
    pend_nxt = (pend_q & ~clr_vec) | set_vec;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      any_q  <= 1'b0;
    end else begin
      pend_q <= pend_nxt;
      any_q  <= |pend_nxt;
    end
  end
endmodule

// File: rtl/edge_wake_detector.sv
module edge_wake_detector
  import ewd_pkg::*;
#(
  parameter int N = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N-1:0]      pin_lvl,
  input  logic [N-1:0]      sleep_ctl,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [N-1:0]      wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [N-1:0]      rd_data,
  output logic              irq_o,
  output logic              wake_o
);
  logic [N-1:0]                rise_v;
  logic [N-1:0]                fall_v;
  logic [NUM_MASKS-1:0][N-1:0] masks;
  logic [N-1:0]                irq_set;
  logic [N-1:0]                wake_set;
  logic [N-1:0]                ack_vec;
  logic [N-1:0]                status_q;
  logic [N-1:0]                wpend_q;
  logic [N-1:0]                rd_q;

  ewd_edge_sense #(.N(N)) u_edge (
    .clk  (clk),
    .rst  (rst),
    .lvl  (pin_lvl),
    .rise (rise_v),
    .fall (fall_v)
  );

  ewd_cfg_regs #(.N(N)) u_cfg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .masks   (masks)
  );

  always_comb begin
    irq_set  = (rise_v & masks[SEL_RISE_IRQ]) | (fall_v & masks[SEL_FALL_IRQ]);
    wake_set = ((rise_v & masks[SEL_RISE_WAKE]) | (fall_v & masks[SEL_FALL_WAKE]))
               & ~sleep_ctl;
    ack_vec  = (wr_en && (wr_addr == SEL_CLEAR)) ? wr_data : '0;
  end

  ewd_sticky #(.N(N)) u_irq_pend (
    .clk     (clk),
    .rst     (rst),
    .set_vec (irq_set),
    .clr_vec (ack_vec),
    .pend_q  (status_q),
    .any_q   (irq_o)
  );

  ewd_sticky #(.N(N)) u_wake_pend (
    .clk     (clk),
    .rst     (rst),
    .set_vec (wake_set),
    .clr_vec (ack_vec),
    .pend_q  (wpend_q),
    .any_q   (wake_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= '0;
    end else begin
      unique case (reg_sel_e'(rd_addr))
        SEL_RISE_IRQ:  rd_q <= masks[SEL_RISE_IRQ];
        SEL_FALL_IRQ:  rd_q <= masks[SEL_FALL_IRQ];
        SEL_RISE_WAKE: rd_q <= masks[SEL_RISE_WAKE];
        SEL_FALL_WAKE: rd_q <= masks[SEL_FALL_WAKE];
        SEL_STATUS:    rd_q <= status_q;
        SEL_WAKE_PEND: rd_q <= wpend_q;
        default:       rd_q <= '0;
      endcase
    end
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/ewd_checker.sv
module ewd_checker
  import ewd_pkg::*;
#(
  parameter int N = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [N-1:0]      sleep_ctl,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [N-1:0]      wr_data,
  input logic [N-1:0]      rise_v,
  input logic [N-1:0]      fall_v,
  input logic [N-1:0]      irq_set,
  input logic [N-1:0]      status_q,
  input logic [N-1:0]      wpend_q,
  input logic              irq_o,
  input logic              wake_o
);
  logic [N-1:0] clr_seen;
  assign clr_seen = (wr_en && wr_addr == SEL_CLEAR) ? wr_data : '0;

  // R8: interrupt output tracks the status register
  a_r8_irq_is_or: assert property (@(posedge clk) disable iff (rst)
    irq_o == (|status_q));

  // R9: wake output tracks the wake pending register
  a_r9_wake_is_or: assert property (@(posedge clk) disable iff (rst)
    wake_o == (|wpend_q));

  // R7: an edge-driven set always lands, even with a clear in the same cycle
  a_r7_set_wins: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(irq_set) & ~status_q) == '0));

  // R11: a status bit only drops when it was named in a clear write
  a_r11_sticky: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((($past(status_q) & ~$past(clr_seen)) & ~status_q) == '0));

  // R5: a newly set status bit needs an edge on that pin
  a_r5_edge_only: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((status_q & ~$past(status_q) & ~($past(rise_v) | $past(fall_v))) == '0));

  // R10: a pin with its sleep bit high never gains a wake pending bit
  a_r10_sleep_gate: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((wpend_q & ~$past(wpend_q) & $past(sleep_ctl)) == '0));
endmodule

bind edge_wake_detector ewd_checker #(.N(N)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .sleep_ctl (sleep_ctl),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .rise_v    (rise_v),
  .fall_v    (fall_v),
  .irq_set   (irq_set),
  .status_q  (status_q),
  .wpend_q   (wpend_q),
  .irq_o     (irq_o),
  .wake_o    (wake_o)
);

// File: tb/tb_edge_wake_detector.sv
`timescale 1ns/1ps
module tb_edge_wake_detector;
  localparam int N = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  pin_lvl = '0;
  logic [N-1:0]  sleep_ctl = '0;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_addr = '0;
  logic [N-1:0]  wr_data = '0;
  logic [2:0]    rd_addr = '0;
  logic [N-1:0]  rd_data;
  logic          irq_o;
  logic          wake_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  edge_wake_detector #(.N(N)) dut (
    .clk(clk), .rst(rst), .pin_lvl(pin_lvl), .sleep_ctl(sleep_ctl),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq_o(irq_o), .wake_o(wake_o)
  );

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [N-1:0] d);
    @(negedge clk);
    rd_addr = a;
    @(posedge clk); #1;
    d = rd_data;
  endtask

  task automatic pin(input int i, input logic v);
    @(negedge clk);
    pin_lvl[i] = v;
    @(posedge clk); #1;
  endtask

  task automatic clear_all();
    wr(3'd5, '1);
    for (int k = 0; k < 4; k++) wr(k[2:0], '0);
  endtask

  task automatic t_reset();
    logic [N-1:0] d;
    for (int a = 0; a < 8; a++) begin
      rd(a[2:0], d);
      chk("R1 reg after reset", d, '0);
    end
    chk("R1 irq_o after reset", {31'd0, irq_o}, '0);
    chk("R1 wake_o after reset", {31'd0, wake_o}, '0);
  endtask

  task automatic t_readback();
    logic [N-1:0] d;
    wr(3'd0, 32'h1111_0001);
    wr(3'd1, 32'h2222_0002);
    wr(3'd2, 32'h4444_0004);
    wr(3'd3, 32'h8888_0008);
    rd(3'd0, d); chk("R4 word0 readback", d, 32'h1111_0001);
    rd(3'd1, d); chk("R4 word1 readback", d, 32'h2222_0002);
    rd(3'd2, d); chk("R4 word2 readback", d, 32'h4444_0004);
    rd(3'd3, d); chk("R4 word3 readback", d, 32'h8888_0008);
    wr(3'd4, '1); wr(3'd6, '1); wr(3'd7, '1);
    rd(3'd4, d); chk("R6 write to status ignored", d, '0);
    rd(3'd6, d); chk("R6 write to wake pend ignored", d, '0);
    rd(3'd7, d); chk("R6 spare word reads 0", d, '0);
    rd(3'd5, d); chk("R6 clear word reads 0", d, '0);
    clear_all();
  endtask

  task automatic t_rise();
    logic [N-1:0] d;
    wr(3'd0, 32'h1);
    pin(0, 1'b1);
    chk("R8 irq_o same edge as status", {31'd0, irq_o}, 32'd1);
    rd(3'd4, d); chk("R2 rise sets status", d, 32'h1);
    wr(3'd5, 32'h1);
    chk("R8 irq_o low after clear", {31'd0, irq_o}, '0);
    pin(0, 1'b0);
    rd(3'd4, d); chk("R2 falling edge ignored by rise mask", d, '0);
    clear_all();
  endtask

  task automatic t_fall();
    logic [N-1:0] d;
    wr(3'd1, 32'h2);
    pin(1, 1'b1);
    rd(3'd4, d); chk("R3 rising edge ignored by fall mask", d, '0);
    pin(1, 1'b0);
    rd(3'd4, d); chk("R3 fall sets status", d, 32'h2);
    clear_all();
  endtask

  task automatic t_both();
    logic [N-1:0] d;
    wr(3'd0, 32'h4); wr(3'd1, 32'h4);
    pin(2, 1'b1);
    rd(3'd4, d); chk("R4 both-edge pin rise", d, 32'h4);
    wr(3'd5, 32'h4);
    pin(2, 1'b0);
    rd(3'd4, d); chk("R4 both-edge pin fall", d, 32'h4);
    clear_all();
  endtask

  task automatic t_level();
    logic [N-1:0] d;
    wr(3'd0, 32'h8);
    pin(3, 1'b1);
    wr(3'd5, 32'h8);
    repeat (10) @(posedge clk);
    #1;
    chk("R5 held level keeps irq_o low", {31'd0, irq_o}, '0);
    rd(3'd4, d); chk("R5 held level sets nothing", d, '0);
    pin(3, 1'b0);
    clear_all();
  endtask

  task automatic t_partial_clear();
    logic [N-1:0] d;
    wr(3'd0, 32'h30);
    @(negedge clk); pin_lvl[4] = 1'b1; pin_lvl[5] = 1'b1;
    @(posedge clk); #1;
    rd(3'd4, d); chk("R2 two pins latched", d, 32'h30);
    wr(3'd5, 32'h10);
    rd(3'd4, d); chk("R6 partial clear", d, 32'h20);
    chk("R8 irq_o with one bit left", {31'd0, irq_o}, 32'd1);
    pin(4, 1'b0); pin(5, 1'b0);
    clear_all();
  endtask

  task automatic t_set_wins();
    logic [N-1:0] d;
    wr(3'd0, 32'h40);
    pin(6, 1'b1);
    pin(6, 1'b0);
    @(negedge clk);
    pin_lvl[6] = 1'b1;
    wr_en = 1'b1; wr_addr = 3'd5; wr_data = 32'h40;
    @(posedge clk); #1;
    wr_en = 1'b0;
    rd(3'd4, d); chk("R7 set beats clear same cycle", d, 32'h40);
    pin(6, 1'b0);
    clear_all();
  endtask

  task automatic t_mask_off();
    logic [N-1:0] d;
    wr(3'd0, 32'h80);
    pin(7, 1'b1);
    wr(3'd0, 32'h0);
    rd(3'd4, d); chk("R11 status kept after mask cleared", d, 32'h80);
    pin(7, 1'b0);
    clear_all();
  endtask

  task automatic t_wake();
    logic [N-1:0] d;
    wr(3'd2, 32'h100); wr(3'd3, 32'h200);
    pin(8, 1'b1);
    chk("R9 wake_o on rising wake", {31'd0, wake_o}, 32'd1);
    rd(3'd6, d); chk("R9 wake pend rise", d, 32'h100);
    rd(3'd4, d); chk("R9 wake does not set irq status", d, '0);
    pin(9, 1'b1);
    rd(3'd6, d); chk("R9 rise ignored by fall-wake mask", d, 32'h100);
    pin(9, 1'b0);
    rd(3'd6, d); chk("R9 wake pend fall", d, 32'h300);
    wr(3'd5, 32'h100);
    rd(3'd6, d); chk("R12 wake partial clear", d, 32'h200);
    chk("R12 wake_o held with bit left", {31'd0, wake_o}, 32'd1);
    wr(3'd5, 32'h200);
    chk("R12 wake_o low after clear", {31'd0, wake_o}, '0);
    pin(8, 1'b0);
    clear_all();
  endtask

  task automatic t_sleep();
    logic [N-1:0] d;
    wr(3'd2, 32'h400); wr(3'd3, 32'h400); wr(3'd0, 32'h400);
    sleep_ctl = 32'h400;
    pin(10, 1'b1);
    pin(10, 1'b0);
    chk("R10 wake_o blocked by sleep bit", {31'd0, wake_o}, '0);
    rd(3'd6, d); chk("R10 wake pend blocked", d, '0);
    rd(3'd4, d); chk("R10 irq status ignores sleep bit", d, 32'h400);
    sleep_ctl = '0;
    pin(10, 1'b1);
    rd(3'd6, d); chk("R10 wake after sleep bit cleared", d, 32'h400);
    pin(10, 1'b0);
    clear_all();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R13: every rd() samples one clock after presenting the address
    t_reset();
    t_readback();
    t_rise();
    t_fall();
    t_both();
    t_level();
    t_partial_clear();
    t_set_wins();
    t_mask_off();
    t_wake();
    t_sleep();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule